// File: doc/BRIEF.md
# Interrupt Mask Controller with Atomic Set/Clear

This block gathers up to 32 level-sensitive interrupt sources and masks them with an enable register. Software reaches that register through a small register window. The enable register can be loaded whole at one offset. Two further offsets let software change single bits atomically, with no read-modify-write sequence:

- A write-one-to-set offset turns bits on.
- A write-one-to-clear offset turns bits off.

The set and clear offsets have a second role when read. The set offset returns the masked status. The clear offset returns the raw status. One combined request line is driven high whenever any enabled source is active.

Each source is sampled into a register once before it is used. The masked status, the raw status and the request line all follow that registered copy.

A read is requested with a one-cycle strobe. The read data register loads on that clock edge and holds its value until the next strobe.

The control has no sequential states. Each access is sorted by an enumerated register select into one of four classes:

- `SEL_NONE`: unmapped address.
- `SEL_ENABLE`: whole-register load and read-back of the enable register.
- `SEL_SETMASK`: set on write, masked status on read.
- `SEL_CLRRAW`: clear on write, raw status on read.

Every access moves from the idle bus, through exactly one of these classes, back to idle in a single cycle.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the enable register is zero, `irq_o` is 0 and `bus_rdata_o` is zero.
- R2: A write to offset 0x30 loads the whole enable register with the write data. A read at offset 0x30 returns the enable register.
- R3: A write to offset 0x34 sets every enable bit whose write-data bit is 1. All other enable bits keep their value.
- R4: A write to offset 0x38 clears every enable bit whose write-data bit is 1. All other enable bits keep their value.
- R5: A read at offset 0x34 returns the registered sources ANDed bitwise with the enable register.
- R6: A read at offset 0x38 returns the registered sources, whatever the enable bits are.
- R7: `irq_o` is 1 exactly when at least one bit of (registered sources AND enable register) is 1.
- R8: Sources pass through one register stage. A change on `src_i` reaches `irq_o` and the status reads only after the next rising clock edge.
- R9: Writes to any offset other than 0x30, 0x34 and 0x38 change nothing. Reads at such offsets return zero. Without `bus_rd_i`, `bus_rdata_o` holds its last value.
- R10: When a read and a write occur in the same cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_addr_i | input | ADDR_W | Byte offset within the register window |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; loads read data on the same edge |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound checker verifies several behaviours on every cycle:

- Each whole, set and clear write changes exactly the intended enable bits and no others.
- The request line always matches the enabled sources seen one edge earlier.
- Raw and masked reads return the values present before the read edge.
- Read data stays stable without a strobe.

Only the bench's scenarios can show the following:

- Writes to unmapped offsets leave the register untouched, as seen through a later read.
- A read in the same cycle as a write returns the old value.
- Long sequences mixing all three write kinds with changing sources end in the expected enable pattern.

// File: rtl/ime_pkg.sv
package ime_pkg;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_SETMASK = 2'd2,
        SEL_CLRRAW  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ime_src_stage.sv
module ime_src_stage #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] src_q_o
);

    // One flop per source line; levels are sampled, never latched as edges.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= src_i[g];
        end
        assign src_q_o[g] = bit_q;
    end

endmodule

// File: rtl/ime_addr_decode.sv
module ime_addr_decode
    import ime_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_EN  = 8'h30,
    parameter logic [ADDR_W-1:0] OFS_SET = 8'h34,
    parameter logic [ADDR_W-1:0] OFS_CLR = 8'h38
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    always_comb begin
        if      (addr_i == OFS_EN)  sel_o = SEL_ENABLE;
        else if (addr_i == OFS_SET) sel_o = SEL_SETMASK;
        else if (addr_i == OFS_CLR) sel_o = SEL_CLRRAW;
        else                        sel_o = SEL_NONE;
    end

endmodule

// File: rtl/ime_enable_reg.sv
module ime_enable_reg
    import ime_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            unique case (sel_i)
                SEL_ENABLE:  en_d = wdata_i;
                SEL_SETMASK: en_d = en_q | wdata_i;
                SEL_CLRRAW:  en_d = en_q & ~wdata_i;
                SEL_NONE:    en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

endmodule

// File: rtl/ime_read_mux.sv
module ime_read_mux
    import ime_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_i,
    input  reg_sel_e           sel_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] masked_i,
    input  logic [NUM_SRC-1:0] raw_i,
    output logic [NUM_SRC-1:0] rdata_o
);

    logic [NUM_SRC-1:0] rd_d;
    logic [NUM_SRC-1:0] rd_q;

    always_comb begin
        unique case (sel_i)
            SEL_ENABLE:  rd_d = en_i;
            SEL_SETMASK: rd_d = masked_i;
            SEL_CLRRAW:  rd_d = raw_i;
            SEL_NONE:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_q <= '0;
        else if (rd_i) rd_q <= rd_d;
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import ime_pkg::*;
#(
    parameter int                NUM_SRC = 32,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_EN  = 8'h30,
    parameter logic [ADDR_W-1:0] OFS_SET = 8'h34,
    parameter logic [ADDR_W-1:0] OFS_CLR = 8'h38
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_o
);

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] masked;

    ime_src_stage #(.NUM_SRC(NUM_SRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .src_q_o (src_q)
    );

    ime_addr_decode #(
        .ADDR_W  (ADDR_W),
        .OFS_EN  (OFS_EN),
        .OFS_SET (OFS_SET),
        .OFS_CLR (OFS_CLR)
    ) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    ime_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i),
        .en_o    (enable_q)
    );

    assign masked = src_q & enable_q;

    ime_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (bus_rd_i),
        .sel_i    (sel),
        .en_i     (enable_q),
        .masked_i (masked),
        .raw_i    (src_q),
        .rdata_o  (bus_rdata_o)
    );

    assign irq_o = |masked;

endmodule

// File: rtl/ime_checker.sv
module ime_checker #(
    parameter int                NUM_SRC = 32,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] OFS_EN  = 8'h30,
    parameter logic [ADDR_W-1:0] OFS_SET = 8'h34,
    parameter logic [ADDR_W-1:0] OFS_CLR = 8'h38
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_wr_i,
    input logic               bus_rd_i,
    input logic [NUM_SRC-1:0] bus_wdata_i,
    input logic [NUM_SRC-1:0] bus_rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] en_q
);

    // Counts edges since reset release so that $past never reaches into reset.
    logic [1:0] live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             live_q <= 2'd0;
        else if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && irq_o == 1'b0 && bus_rdata_o == '0));

    // R2
    whole_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_EN) |=> en_q == $past(bus_wdata_i));

    // R3
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_SET) |=>
            ((en_q & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
            ((en_q & ~$past(bus_wdata_i)) == ($past(en_q) & ~$past(bus_wdata_i))));

    // R4
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_CLR) |=>
            ((en_q & $past(bus_wdata_i)) == '0) &&
            ((en_q & ~$past(bus_wdata_i)) == ($past(en_q) & ~$past(bus_wdata_i))));

    // R5
    masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && bus_rd_i && bus_addr_i == OFS_SET) |=>
            bus_rdata_o == ($past(en_q) & $past(src_i, 2)));

    // R6
    raw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && bus_rd_i && bus_addr_i == OFS_CLR) |=>
            bus_rdata_o == $past(src_i, 2));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != 2'd0) |-> irq_o == (|(en_q & $past(src_i))));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

endmodule

bind irq_mask_ctrl ime_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .OFS_EN  (OFS_EN),
    .OFS_SET (OFS_SET),
    .OFS_CLR (OFS_CLR)
) u_ime_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .en_q        (enable_q)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;

    localparam int N  = 32;
    localparam int AW = 8;

    typedef struct packed {
        logic [N-1:0]  src;
        logic [AW-1:0] waddr;
        logic [N-1:0]  wdata;
        logic [AW-1:0] raddr;
        logic [N-1:0]  exp_rd;
        logic          exp_irq;
    } vec_t;

    // Each row: drive sources, one write, one read; enable state carries over.
    localparam vec_t VEC [10] = '{
        '{32'hFFFF_FFFF, 8'h30, 32'h0000_00F0, 8'h30, 32'h0000_00F0, 1'b1}, // R2
        '{32'h0000_000F, 8'h34, 32'h0000_0003, 8'h30, 32'h0000_00F3, 1'b1}, // R3
        '{32'h0000_000F, 8'h38, 32'h0000_0001, 8'h30, 32'h0000_00F2, 1'b1}, // R4
        '{32'h0000_00F0, 8'h34, 32'h8000_0000, 8'h34, 32'h0000_00F0, 1'b1}, // R5
        '{32'h8000_0001, 8'h38, 32'h0000_00F2, 8'h34, 32'h8000_0000, 1'b1}, // R5
        '{32'h1234_5678, 8'h38, 32'h8000_0000, 8'h38, 32'h1234_5678, 1'b0}, // R6
        '{32'hA5A5_A5A5, 8'h3C, 32'hFFFF_FFFF, 8'h30, 32'h0000_0000, 1'b0}, // R9
        '{32'hA5A5_A5A5, 8'h30, 32'h0F0F_0F0F, 8'h34, 32'h0505_0505, 1'b1}, // R7
        '{32'h0000_0000, 8'h34, 32'hF0F0_F0F0, 8'h44, 32'h0000_0000, 1'b0}, // R9
        '{32'h0000_0001, 8'h38, 32'hFFFF_FFFE, 8'h34, 32'h0000_0001, 1'b1}  // R7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic [AW-1:0] bus_addr_i = '0;
    logic          bus_wr_i = 1'b0;
    logic          bus_rd_i = 1'b0;
    logic [N-1:0]  bus_wdata_i = '0;
    logic [N-1:0]  bus_rdata_o;
    logic          irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        @(negedge clk);
        bus_rd_i = 1'b0;
        d = bus_rdata_o;
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset values while held and after release
        check("R1 rdata in reset", bus_rdata_o, '0);
        check("R1 irq in reset", {31'd0, irq_o}, '0);
        rst_n = 1'b1;
        src_i = '1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq_o}, '0);
        do_read(8'h30, rd);
        check("R1 enable after reset", rd, '0);

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            src_i = VEC[i].src;
            do_write(VEC[i].waddr, VEC[i].wdata);
            do_read(VEC[i].raddr, rd);
            check($sformatf("R2-R9 table row %0d rdata", i), rd, VEC[i].exp_rd);
            check($sformatf("R7 table row %0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i].exp_irq});
        end

        // R8: enable is 1; a source change appears only after the next edge
        src_i = '0;
        @(negedge clk);
        check("R8 irq low with source low", {31'd0, irq_o}, '0);
        src_i = 32'h0000_0001;
        #1;
        check("R8 irq not yet raised", {31'd0, irq_o}, '0);
        @(negedge clk);
        check("R8 irq raised after one edge", {31'd0, irq_o}, 32'd1);

        // R9: rdata holds without a read strobe
        do_read(8'h38, rd);
        src_i = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        check("R9 rdata held", bus_rdata_o, 32'h0000_0001);

        // R10: same-cycle read and write returns the old enable value
        @(negedge clk);
        bus_wr_i = 1'b1; bus_rd_i = 1'b1; bus_addr_i = 8'h30; bus_wdata_i = 32'h00FF_0000;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_rd_i = 1'b0;
        check("R10 read returns pre-write value", bus_rdata_o, 32'h0000_0001);
        do_read(8'h30, rd);
        check("R10 write took effect", rd, 32'h00FF_0000);
        do_read(8'h34, rd);
        check("R5 masked after load", rd, 32'h00FF_0000);

        // R1: reset mid-run clears enable, irq and rdata
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq after mid reset", {31'd0, irq_o}, '0);
        check("R1 rdata after mid reset", bus_rdata_o, '0);
        rst_n = 1'b1;
        do_read(8'h30, rd);
        check("R1 enable after mid reset", rd, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule